// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block applies one single-bit shift, rotate or bitwise complement to an operand of 8, 16 or 32 bits. Software-visible arithmetic is not its concern. It serves as the shift slice of a processor datapath. The caller supplies an operation code, a size select, the operand and the current carry flag. The unit returns the result at the chosen width together with fresh negative, zero, overflow and carry flags.

The logic that computes the result is purely combinational. The unit builds one lane per width in parallel and steers the lane that the size select names to the output. A single register stage with a valid strobe holds the result and flags, so a result appears one clock after its request. While no request is present, the last result is held.

Top module: `shrot_unit`

## Requirements
- R1: The operation code `op` selects one of nine operations: 0 logical shift left, 1 logical shift right, 2 arithmetic shift left, 3 arithmetic shift right, 4 rotate left, 5 rotate right, 6 rotate left through carry, 7 rotate right through carry, 8 bitwise complement.
- R2: `size_sel` picks the width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. The top bit of the chosen width (bit 7, 15 or 31) is the high bit.
- R3: Every left shift or rotate (codes 0, 2, 4, 6) puts the outgoing high bit in C. Every right shift or rotate (codes 1, 3, 5, 7) puts the outgoing bit 0 in C.
- R4: Logical shift right fills the vacated high bit with 0. Both left shifts (codes 0 and 2) fill bit 0 with 0.
- R5: Arithmetic shift right leaves the original high bit in place, so the sign is kept.
- R6: Rotate left moves the outgoing high bit into bit 0. Rotate right moves the outgoing bit 0 into the high bit.
- R7: Rotate left through carry puts the incoming carry into bit 0. Rotate right through carry puts the incoming carry into the high bit.
- R8: The complement inverts every bit of the selected width, and C keeps the value of `carry_in`.
- R9: N equals the high bit of the result at the selected width. Z is 1 exactly when the result at that width is zero. V is always 0.
- R10: Operand bits above the selected width have no effect, and result bits above it are driven to 0.
- R11: Codes 9 to 15 pass the operand through unchanged at the selected width, and C keeps `carry_in`.
- R12: A request with `in_valid` high yields `out_valid` high one clock later with its result and flags. A cycle without a request yields `out_valid` low one clock later, and the result and flags keep their previous values.
- R13: While `rst_n` is low, `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| size_sel | input | 2 | Width select |
| operand | input | 32 | Source operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one clock after the request |
| result | output | 32 | Result, zero above the selected width |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag |

## Verification
Two things can happen in the same clock. A new request can be captured while the previous result is on the outputs. The incoming carry can also be consumed as a data bit by a through-carry rotate while a fresh C is produced. The bench issues requests back to back across every code, width and both carry values, so both situations recur on every edge. A scoreboard queue checks that each result arrives in order, one clock late, with its own carry and no bleed from the neighbouring request. Idle gaps then show that a missing request clears `out_valid` without disturbing the held result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [3:0] {
      OP_SHL  = 4'd0,
      OP_SHR  = 4'd1,
      OP_SAL  = 4'd2,
      OP_SAR  = 4'd3,
      OP_ROL  = 4'd4,
      OP_ROR  = 4'd5,
      OP_RCL  = 4'd6,
      OP_RCR  = 4'd7,
      OP_NOT  = 4'd8
   } shrot_op_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_ALT  = 2'd3
   } shrot_size_e;

   localparam int NUM_LANES = 3;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int LW = 8
) (
   input  logic [3:0]    op_i,
   input  logic [LW-1:0] a_i,
   input  logic          c_i,
   output logic [LW-1:0] r_o,
   output logic          c_o
);

   localparam int HB = LW - 1;

   generate
      if (LW < 2) begin : g_bad_lane
         $error("shrot_lane: LW must be at least 2");
      end
   endgenerate

   logic hi_bit;
   logic lo_bit;

   assign hi_bit = a_i[HB];
   assign lo_bit = a_i[0];

   always_comb begin
      r_o = a_i;
      c_o = c_i;
      case (shrot_op_e'(op_i))
         OP_SHL, OP_SAL: begin
            r_o = {a_i[HB-1:0], 1'b0};
            c_o = hi_bit;
         end
         OP_SHR: begin
            r_o = {1'b0, a_i[HB:1]};
            c_o = lo_bit;
         end
         OP_SAR: begin
            r_o = {hi_bit, a_i[HB:1]};
            c_o = lo_bit;
         end
         OP_ROL: begin
            r_o = {a_i[HB-1:0], hi_bit};
            c_o = hi_bit;
         end
         OP_ROR: begin
            r_o = {lo_bit, a_i[HB:1]};
            c_o = lo_bit;
         end
         OP_RCL: begin
            r_o = {a_i[HB-1:0], c_i};
            c_o = hi_bit;
         end
         OP_RCR: begin
            r_o = {c_i, a_i[HB:1]};
            c_o = lo_bit;
         end
         OP_NOT: begin
            r_o = ~a_i;
            c_o = c_i;
         end
         default: begin
            r_o = a_i;
            c_o = c_i;
         end
      endcase
   end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
   import shrot_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] value_i,
   output logic              n_o,
   output logic              z_o
);

   localparam int BW = DATA_W / 4;
   localparam int WW = DATA_W / 2;
   localparam logic [DATA_W-1:0] MASK_B = DATA_W'({BW{1'b1}});
   localparam logic [DATA_W-1:0] MASK_W = DATA_W'({WW{1'b1}});
   localparam logic [DATA_W-1:0] MASK_L = {DATA_W{1'b1}};

   logic [DATA_W-1:0] width_mask;

   always_comb begin
      case (shrot_size_e'(size_i))
         SZ_BYTE: begin
            width_mask = MASK_B;
            n_o        = value_i[BW-1];
         end
         SZ_WORD: begin
            width_mask = MASK_W;
            n_o        = value_i[WW-1];
         end
         default: begin
            width_mask = MASK_L;
            n_o        = value_i[DATA_W-1];
         end
      endcase
      z_o = ((value_i & width_mask) == '0);
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [1:0]        size_sel,
   input  logic [DATA_W-1:0] operand,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);

   localparam int BW = DATA_W / 4;

   generate
      if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
         $error("shrot_unit: DATA_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic [DATA_W-1:0] lane_res [NUM_LANES];
   logic              lane_c   [NUM_LANES];

   generate
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
         logic [LW-1:0] lw_res;
         logic          lw_c;

         shrot_lane #(.LW(LW)) i_lane (
            .op_i (op),
            .a_i  (operand[LW-1:0]),
            .c_i  (carry_in),
            .r_o  (lw_res),
            .c_o  (lw_c)
         );

         assign lane_res[g] = DATA_W'(lw_res);
         assign lane_c[g]   = lw_c;
      end
   endgenerate

   logic [DATA_W-1:0] sel_res;
   logic              sel_c;
   logic              nxt_n;
   logic              nxt_z;

   always_comb begin
      case (shrot_size_e'(size_sel))
         SZ_BYTE: begin
            sel_res = lane_res[0];
            sel_c   = lane_c[0];
         end
         SZ_WORD: begin
            sel_res = lane_res[1];
            sel_c   = lane_c[1];
         end
         default: begin
            sel_res = lane_res[2];
            sel_c   = lane_c[2];
         end
      endcase
   end

   shrot_flags #(.DATA_W(DATA_W)) i_flags (
      .size_i  (size_sel),
      .value_i (sel_res),
      .n_o     (nxt_n),
      .z_o     (nxt_z)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= sel_res;
            flag_n <= nxt_n;
            flag_z <= nxt_z;
            flag_c <= sel_c;
         end
      end
   end

   assign flag_v = 1'b0;

   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(flag_c) && $stable(flag_n) && $stable(flag_z)));

   assert_not_keeps_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_NOT) |=> (flag_c == $past(carry_in)));

   assert_byte_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && size_sel == SZ_BYTE) |=> (result[DATA_W-1:BW] == '0));

   assert_sar_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_SAR && size_sel == SZ_BYTE) |=> (flag_n == $past(operand[BW-1])));

   assert_rcl_carry_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_RCL) |=> (result[0] == $past(carry_in)));

endmodule

// File: tb/test_shrot_unit.sv
module test_shrot_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 50000;

   typedef struct {
      logic [31:0] res;
      logic        n;
      logic        z;
      logic        c;
      logic [1:0]  sz;
      string       tag_r;
      string       tag_c;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  size_sel = '0;
   logic [31:0] operand = '0;
   logic        carry_in = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int fails = 0;
   exp_t sb_q[$];
   logic [31:0] last_seen = '0;
   int popped = 0;
   int pushed = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shrot_unit i_shrot_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .size_sel  (size_sel),
      .operand   (operand),
      .carry_in  (carry_in),
      .out_valid (out_valid),
      .result    (result),
      .flag_n    (flag_n),
      .flag_z    (flag_z),
      .flag_v    (flag_v),
      .flag_c    (flag_c)
   );

   task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(logic [3:0] o, logic [1:0] sz, logic [31:0] x, logic cin);
      exp_t e;
      int w;
      logic [31:0] mask, a, r;
      logic hb, c;
      w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      a = x & mask;
      hb = a[w-1];
      case (o)
         4'd0, 4'd2: begin r = (a << 1) & mask; c = hb; end
         4'd1: begin r = a >> 1; c = a[0]; end
         4'd3: begin r = (a >> 1) | (32'(hb) << (w-1)); c = a[0]; end
         4'd4: begin r = ((a << 1) | 32'(hb)) & mask; c = hb; end
         4'd5: begin r = (a >> 1) | (32'(a[0]) << (w-1)); c = a[0]; end
         4'd6: begin r = ((a << 1) | 32'(cin)) & mask; c = hb; end
         4'd7: begin r = (a >> 1) | (32'(cin) << (w-1)); c = a[0]; end
         4'd8: begin r = ~a & mask; c = cin; end
         default: begin r = a; c = cin; end
      endcase
      e.res = r;
      e.n = r[w-1];
      e.z = (r == 32'd0);
      e.c = c;
      e.sz = sz;
      case (o)
         4'd0, 4'd1, 4'd2: e.tag_r = "R1 R2 R4";
         4'd3: e.tag_r = "R1 R2 R5";
         4'd4, 4'd5: e.tag_r = "R1 R2 R6";
         4'd6, 4'd7: e.tag_r = "R1 R2 R7";
         4'd8: e.tag_r = "R1 R2 R8";
         default: e.tag_r = "R11";
      endcase
      if (o == 4'd6 || o == 4'd7) e.tag_c = "R3 R7";
      else if (o == 4'd8) e.tag_c = "R8";
      else if (o > 4'd8) e.tag_c = "R11";
      else e.tag_c = "R3";
      return e;
   endfunction

   task automatic drive(logic [3:0] o, logic [1:0] sz, logic [31:0] x, logic cin);
      @(negedge clk);
      in_valid = 1'b1;
      op = o;
      size_sel = sz;
      operand = x;
      carry_in = cin;
      sb_q.push_back(model(o, sz, x, cin));
      pushed++;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      operand = 32'hA5A5_A5A5;
      carry_in = ~carry_in;
   endtask

   // Scoreboard monitor: compares each result as it is presented.
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
               checks++;
               fails++;
               $display("FAIL R12 unexpected result: actual=%h expected=none", result);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               popped++;
               check_eq(e.tag_r, "result", result, e.res);
               check_eq(e.tag_c, "carry", 32'(flag_c), 32'(e.c));
               check_eq("R9", "negative", 32'(flag_n), 32'(e.n));
               check_eq("R9", "zero", 32'(flag_z), 32'(e.z));
               check_eq("R9", "overflow", 32'(flag_v), 32'd0);
               if (e.sz == 2'd0)
                  check_eq("R10", "upper bits", result & 32'hFFFF_FF00, 32'd0);
               else if (e.sz == 2'd1)
                  check_eq("R10", "upper bits", result & 32'hFFFF_0000, 32'd0);
            end
            last_seen = result;
         end
      end
   end

   initial begin
      #(CLK_PERIOD * WATCHDOG_CYCLES);
      fails++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] pats [6];
      logic [31:0] held;
      int n_items;
      pats[0] = 32'h0000_0000;
      pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_8080;
      pats[3] = 32'h0000_0001;
      pats[4] = 32'h1234_5601;
      pats[5] = 32'h7F7F_7FFE;

      // R13: reset state
      repeat (3) @(negedge clk);
      check_eq("R13", "out_valid in reset", 32'(out_valid), 32'd0);
      check_eq("R13", "result in reset", result, 32'd0);
      check_eq("R13", "flags in reset", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R12", "out_valid after reset idle", 32'(out_valid), 32'd0);

      n_items = 0;
      for (int o = 0; o < 16; o++) begin
         for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 6; p++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  drive(4'(o), 2'(s), pats[p], 1'(ci));
                  n_items++;
                  if ((n_items % 37) == 0) idle();
               end
            end
         end
      end

      // Targeted corner cases
      drive(4'd3, 2'd1, 32'hFFFF_8000, 1'b0);  // R5 sign kept at 16 bits
      drive(4'd7, 2'd0, 32'h0000_0000, 1'b1);  // R7 carry into bit 7
      drive(4'd6, 2'd2, 32'h8000_0000, 1'b1);  // R7 carry into bit 0, high bit out
      drive(4'd8, 2'd0, 32'hFFFF_FFFF, 1'b1);  // R8 complement to zero
      drive(4'd0, 2'd0, 32'hFFFF_FF80, 1'b0);  // R10 upper ignored, result zero

      // R12: an idle cycle clears the strobe and holds the result
      idle();
      @(negedge clk);
      held = last_seen;
      check_eq("R12", "out_valid after idle", 32'(out_valid), 32'd0);
      check_eq("R12", "result held", result, held);
      check_eq("R12", "zero flag held", 32'(flag_z), 32'd1);
      repeat (2) @(negedge clk);
      check_eq("R12", "result still held", result, held);

      check_eq("R12", "queue drained", 32'(sb_q.size()), 32'd0);
      check_eq("R12", "results received", 32'(popped), 32'(pushed));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule